// File: doc/BRIEF.md
# Sequential Signed Integer Divider

This block divides one two's-complement integer by another over a fixed number of clock cycles. It produces a quotient that is truncated toward zero and a remainder that satisfies dividend = quotient × divisor + remainder. The operand magnitudes go through a bit-serial restoring core. That core keeps a partial-remainder accumulator and a quotient shift register, and it settles one quotient bit per cycle. A final stage then puts back the signs. The quotient is negated when the operand signs differ. A nonzero remainder always carries the sign of the dividend.

A caller presents both operands with a one-cycle `start` while the block is idle. It then waits for the one-cycle `done` pulse. The results and the two exception flags stay on the outputs until the next `done`. A zero divisor and the single overflowing case (the most negative value divided by −1) finish with the same latency as any other division. Both raise a flag.

The controller has three states:
- `ST_IDLE` waits for `start`. The transition accept moves it to `ST_RUN`.
- `ST_RUN` steps the core once per cycle. The transition last-step moves it to `ST_FIX` after W steps.
- `ST_FIX` registers the sign-corrected results and raises `done`. The transition finish returns it to `ST_IDLE`.

Top module: `sdiv_top`

## Requirements
- R1: For a nonzero divisor, except the overflow case, the quotient equals the true quotient truncated toward zero. Its magnitude is floor(|dividend| / |divisor|), and it is negative exactly when the operand signs differ and the magnitude is nonzero.
- R2: For a nonzero divisor, the remainder satisfies dividend = quotient × divisor + remainder with |remainder| < |divisor|. A nonzero remainder has the sign bit of the dividend.
- R3: The four sign combinations of 7 and 2 give the following results. −7 ÷ 2 gives quotient −3 and remainder −1. 7 ÷ −2 gives −3 and +1. −7 ÷ −2 gives +3 and −1. 7 ÷ 2 gives +3 and +1.
- R4: A zero divisor sets `div_zero` to 1 and `overflow` to 0. It returns a quotient of all ones and the dividend unchanged as the remainder.
- R5: The most negative value divided by −1 sets `overflow` to 1 and `div_zero` to 0. It returns the most negative value as the quotient and 0 as the remainder.
- R6: `start` is sampled at a rising edge while `busy` is 0. `busy` is 1 from the next cycle on. `done` is 1 for exactly one cycle, which follows rising edge number W+1 after the sampling edge. In that same cycle `busy` is 0.
- R7: A `start` raised while `busy` is 1 is ignored. The result of the running division is unchanged, and no further division follows it.
- R8: Quotient, remainder, `div_zero` and `overflow` hold their values from one `done` pulse until the next.
- R9: After reset `busy`, `done`, `div_zero` and `overflow` are 0, and quotient and remainder are 0.
- R10: A `start` presented during the `done` cycle is accepted. The next result appears W+2 cycles later, as in R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a division; taken only while not busy |
| dividend | input | W | Signed dividend, sampled with an accepted start |
| divisor | input | W | Signed divisor, sampled with an accepted start |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: new results are valid |
| quotient | output | W | Signed quotient, truncated toward zero |
| remainder | output | W | Signed remainder, sign of the dividend |
| div_zero | output | 1 | Last division had a zero divisor |
| overflow | output | 1 | Last division was most-negative ÷ −1 |

## Verification
The result pulse and the acceptance of a new request can fall in the same cycle. The `ST_FIX` to `ST_IDLE` transition releases `busy` exactly while `done` is high. The bench provokes this by raising `start` with fresh operands in the very cycle it sees `done`. It then judges both the results delivered in that cycle and the second result, which must arrive W+2 cycles later with correct values. A second pattern raises `start` in mid-run and confirms that it neither disturbs the running result nor launches a further division.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } sdiv_state_e;

endpackage

// File: rtl/sdiv_restore_core.sv
// Bit-serial restoring divider on unsigned magnitudes.
// load: clear the accumulator, take the dividend into the shift register.
// step: shift the pair left, trial-subtract, keep or drop the difference.
module sdiv_restore_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dvd_mag,
    input  logic [W-1:0] dvs_mag,
    output logic [W-1:0] rem_mag,
    output logic [W-1:0] quo_mag
);
    logic [W-1:0] acc;
    logic [W-1:0] mq;
    logic [W-1:0] dvs;
    logic [W:0]   shifted;
    logic [W:0]   trial;
    logic         neg;

    always_comb begin
        shifted = {acc, mq[W-1]};
        trial   = shifted - {1'b0, dvs};
        neg     = trial[W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            mq  <= '0;
            dvs <= '0;
        end else if (load) begin
            acc <= '0;
            mq  <= dvd_mag;
            dvs <= dvs_mag;
        end else if (step) begin
            // a negative trial restores the shifted value, quotient bit 0
            acc <= neg ? shifted[W-1:0] : trial[W-1:0];
            mq  <= {mq[W-2:0], ~neg};
        end
    end

    assign rem_mag = acc;
    assign quo_mag = mq;
endmodule

// File: rtl/sdiv_sign_fix.sv
// Applies operand signs to the unsigned core results, and overrides them
// for a zero divisor.
module sdiv_sign_fix #(
    parameter int W = 32
) (
    input  logic         dvd_neg,
    input  logic         dvs_neg,
    input  logic         dvs_zero,
    input  logic [W-1:0] dvd_raw,
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    output logic [W-1:0] quo_out,
    output logic [W-1:0] rem_out
);
    always_comb begin
        if (dvs_zero) begin
            quo_out = '1;
            rem_out = dvd_raw;
        end else begin
            quo_out = (dvd_neg ^ dvs_neg) ? (~quo_mag + 1'b1) : quo_mag;
            rem_out = dvd_neg ? (~rem_mag + 1'b1) : rem_mag;
        end
    end
endmodule

// File: rtl/sdiv_top.sv
module sdiv_top
    import sdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_zero,
    output logic         overflow
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);
    localparam logic [W-1:0]  MOST_NEG = {1'b1, {(W-1){1'b0}}};

    sdiv_state_e state, state_nx;

    logic [CW-1:0] step_cnt;
    logic          accept;
    logic          last_step;
    logic [W-1:0]  dvd_mag, dvs_mag;
    logic [W-1:0]  core_rem, core_quo;
    logic [W-1:0]  fix_quo, fix_rem;
    logic          hold_dvd_neg, hold_dvs_neg, hold_zero, hold_ovf;
    logic [W-1:0]  hold_dvd;

    assign accept    = start && (state == ST_IDLE);
    assign last_step = (state == ST_RUN) && (step_cnt == LAST);
    assign dvd_mag   = dividend[W-1] ? (~dividend + 1'b1) : dividend;
    assign dvs_mag   = divisor[W-1]  ? (~divisor + 1'b1)  : divisor;
    assign busy      = (state != ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)    state_nx = ST_RUN;
            ST_RUN:  if (last_step) state_nx = ST_FIX;
            ST_FIX:                 state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // step counter and captured operand attributes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_cnt     <= '0;
            hold_dvd_neg <= 1'b0;
            hold_dvs_neg <= 1'b0;
            hold_zero    <= 1'b0;
            hold_ovf     <= 1'b0;
            hold_dvd     <= '0;
        end else if (accept) begin
            step_cnt     <= '0;
            hold_dvd_neg <= dividend[W-1];
            hold_dvs_neg <= divisor[W-1];
            hold_zero    <= (divisor == '0);
            hold_ovf     <= (dividend == MOST_NEG) && (divisor == '1);
            hold_dvd     <= dividend;
        end else if (state == ST_RUN) begin
            step_cnt     <= step_cnt + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
            div_zero  <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            done <= (state == ST_FIX);
            if (state == ST_FIX) begin
                quotient  <= fix_quo;
                remainder <= fix_rem;
                div_zero  <= hold_zero;
                overflow  <= hold_ovf;
            end
        end
    end

    sdiv_restore_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .step    (state == ST_RUN),
        .dvd_mag (dvd_mag),
        .dvs_mag (dvs_mag),
        .rem_mag (core_rem),
        .quo_mag (core_quo)
    );

    sdiv_sign_fix #(.W(W)) u_fix (
        .dvd_neg  (hold_dvd_neg),
        .dvs_neg  (hold_dvs_neg),
        .dvs_zero (hold_zero),
        .dvd_raw  (hold_dvd),
        .quo_mag  (core_quo),
        .rem_mag  (core_rem),
        .quo_out  (fix_quo),
        .rem_out  (fix_rem)
    );
endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         div_zero,
    input logic         overflow
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] op_a, op_b;
    int unsigned  lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_a <= '0;
            op_b <= '0;
            lat  <= 32'hFFFF_FFFF;
        end else if (start && !busy) begin
            op_a <= dividend;
            op_b <= divisor;
            lat  <= 0;
        end else if (lat != 32'hFFFF_FFFF) begin
            lat  <= lat + 1;
        end
    end

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r6_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat == W + 1));
    a_r8_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder)
                   && $stable(div_zero) && $stable(overflow)));
    a_r2_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && remainder != '0) |-> (remainder[W-1] == op_a[W-1]));
    a_r1_quo_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && !overflow && quotient != '0)
            |-> (quotient[W-1] == (op_a[W-1] ^ op_b[W-1])));
    a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (div_zero == (op_b == '0)));
    a_r5_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (overflow == ((op_a == MOST_NEG) && (op_b == '1))));
    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(div_zero && overflow));
endmodule

bind sdiv_top sdiv_checker #(.W(W)) u_sdiv_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .div_zero  (div_zero),
    .overflow  (overflow)
);

// File: tb/sdiv_top_test.sv
`timescale 1ns/1ps
module sdiv_top_test;
    localparam int W = 5;
    localparam int LO = -(1 << (W-1));
    localparam int HI = (1 << (W-1)) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_zero, overflow;
    logic [W-1:0] quotient, remainder;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    sdiv_top #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder),
        .div_zero(div_zero), .overflow(overflow)
    );

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<150000", cycles);
            summary_and_end();
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected results from the requirements
    task automatic expect_of(input int a, input int b,
                             output logic [W-1:0] q, output logic [W-1:0] r,
                             output logic dz, output logic ov);
        dz = 1'b0; ov = 1'b0;
        if (b == 0) begin
            q = '1; r = W'(a); dz = 1'b1;              // R4
        end else if (a == LO && b == -1) begin
            q = W'(LO); r = '0; ov = 1'b1;            // R5
        end else begin
            q = W'(a / b); r = W'(a % b);             // R1 R2
        end
    endtask

    task automatic launch(input int a, input int b);
        @(negedge clk);
        dividend = W'(a);
        divisor  = W'(b);
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    // waits for done at negedges; returns negedges counted since launch edge
    task automatic wait_done(output int k);
        k = 1;
        while (!done && k < 100) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic judge(input string tag, input int a, input int b);
        logic [W-1:0] q, r;
        logic dz, ov;
        expect_of(a, b, q, r, dz, ov);
        check(tag, {quotient, remainder, div_zero, overflow}, {q, r, dz, ov});
    endtask

    initial begin
        int k;
        logic [W-1:0] q_keep;
        // R9 reset state
        repeat (3) @(negedge clk);
        check("R9 reset", {busy, done, quotient, remainder, div_zero, overflow}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 sign combinations
        launch(-7, 2);  wait_done(k); check("R3 -7/2", {quotient, remainder}, {W'(-3), W'(-1)});
        launch(7, -2);  wait_done(k); check("R3 7/-2", {quotient, remainder}, {W'(-3), W'(1)});
        launch(-7, -2); wait_done(k); check("R3 -7/-2", {quotient, remainder}, {W'(3), W'(-1)});
        launch(7, 2);   wait_done(k); check("R3 7/2", {quotient, remainder}, {W'(3), W'(1)});

        // R6 latency and busy
        @(negedge clk);
        dividend = W'(13); divisor = W'(4); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R6 busy after accept", busy, 1'b1);
        wait_done(k);
        check("R6 latency", k, W + 2);
        check("R6 busy low at done", busy, 1'b0);
        @(negedge clk);
        check("R6 done single cycle", done, 1'b0);

        // R8 hold
        q_keep = quotient;
        repeat (5) @(negedge clk);
        check("R8 hold", {quotient, remainder}, {q_keep, W'(1)});

        // R7 start while busy ignored
        launch(-11, 3);
        repeat (2) @(negedge clk);
        dividend = W'(9); divisor = W'(-2); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(k);
        check("R7 latency unchanged", k, W + 2 - 1 - 2);
        judge("R7 result of first op", -11, 3);
        repeat (W + 4) @(negedge clk);
        check("R7 no second op", {busy, done}, 2'b00);
        judge("R7 result retained", -11, 3);

        // R10 back-to-back
        launch(14, -5);
        wait_done(k);
        judge("R10 first", 14, -5);
        dividend = W'(-15); divisor = W'(6); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(k);
        check("R10 second latency", k, W + 2);
        judge("R10 second", -15, 6);

        // R4 / R5 corners
        launch(LO, 0);  wait_done(k); judge("R4 zero divisor, most negative", LO, 0);
        launch(LO, -1); wait_done(k); judge("R5 overflow", LO, -1);

        // R1 R2 R4 R5 exhaustive sweep
        for (int a = LO; a <= HI; a++) begin
            for (int b = LO; b <= HI; b++) begin
                launch(a, b);
                wait_done(k);
                if (b == 0)                   judge("R4 sweep", a, b);
                else if (a == LO && b == -1)  judge("R5 sweep", a, b);
                else                          judge("R1 R2 sweep", a, b);
            end
        end

        summary_and_end();
    end
endmodule